// File: doc/BRIEF.md
# Critical Interrupt Acceptance Unit

This unit decides when a processor core takes a critical-input interrupt. An asynchronous request line from outside the core is first brought into the clock domain by a two-flop synchronizer. The synchronized request is then checked against two enable bits held in the machine state word and against a flag that says a higher-priority exception is pending. The request is level-sensitive. While it is masked or blocked it stays pending, and it is taken on the first cycle in which it is both enabled and unblocked.

When the unit takes the interrupt, it raises a one-cycle take pulse and produces a redirect address. That address is the vector prefix with a fixed low-order offset (0x020) placed below it. In the same cycle the unit copies the interrupted program counter and the machine state word into a pair of critical save registers. It then clears both enable bits so that the interrupt cannot re-enter at once. A return strobe reverses this: it restores the state word from the save register and sends the program counter back to the saved address.

The unit also holds the exception syndrome register and applies its update rules. An update can leave the register unchanged, set a single bit of an exclusive group while clearing all others, or load any subset of bits while clearing the rest. A critical interrupt leaves the syndrome register unchanged.

Top module: `crit_irq_accept`

## Requirements
- R1: A request that goes high while the interrupt is enabled and unblocked gives a take pulse on the third rising clock edge after it rises. The pulse lasts exactly one cycle.
- R2: The interrupt is enabled when the state word has bit CE_POS (default 17) set, or bit GS_POS (default 28) set. Either bit alone is enough. With neither bit set, no pulse is given.
- R3: While hi_pri_pend is high, no take pulse is given.
- R4: A request that is masked stays pending. If the state word is later written so that it enables the interrupt, the interrupt is taken exactly once.
- R5: On a take, redirect_pc equals {ivpr_pfx, 12'h020}.
- R6: On a take, csrr0 receives cur_pc and csrr1 receives the state word as it was before the take. The state word then has bits CE_POS and GS_POS cleared, and all its other bits are unchanged.
- R7: A return strobe (rfci) gives a one-cycle ret pulse. It loads the state word from csrr1 and sets redirect_pc to csrr0. If a return and a take would happen in the same cycle, the return wins and the take is deferred.
- R8: The syndrome register (syn) keeps its value when syn_mode is 0, when no update is strobed, and when a critical interrupt is taken.
- R9: syn_mode 1 (exclusive group) loads syn with only the lowest set bit of syn_bits, and clears every other bit. If syn_bits is zero, syn becomes zero.
- R10: syn_mode 2 (combinational group) loads syn with syn_bits exactly, including all bits set or none.
- R11: After reset, take, ret, the state word, csrr0, csrr1, redirect_pc and syn are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crit_req_async | input | 1 | Asynchronous critical-input request, level-sensitive |
| hi_pri_pend | input | 1 | A higher-priority exception is pending |
| cur_pc | input | PC_W | Program counter of the interrupted instruction |
| ivpr_pfx | input | PC_W-OFS_W | Vector prefix |
| msr_wr | input | 1 | Write strobe for the state word (lowest priority) |
| msr_wdata | input | MSR_W | State word write data |
| rfci | input | 1 | Return-from-critical strobe |
| syn_upd | input | 1 | Syndrome update strobe |
| syn_mode | input | 2 | 0 keep, 1 exclusive group, 2 combinational group, 3 keep |
| syn_bits | input | SYN_W | Candidate syndrome bits |
| take | output | 1 | One-cycle interrupt-taken pulse |
| ret | output | 1 | One-cycle return pulse |
| redirect_pc | output | PC_W | Fetch redirect address |
| msr | output | MSR_W | Current state word |
| csrr0 | output | PC_W | Saved program counter |
| csrr1 | output | MSR_W | Saved state word |
| syn | output | SYN_W | Syndrome register |

## Verification
The bench builds the unit with its default parameters: a 32-bit program counter and state word, a 12-bit vector offset and a 16-bit syndrome register. This places the two enable bits at 17 and 28, far apart. Other state bits are set to non-zero values, so a clear that touched the wrong bit would show up in the state word. The 16-bit syndrome width is wide enough for multi-bit patterns, which show whether exclusive updates keep the lowest set bit and whether combinational updates keep every bit.

// File: rtl/crit_irq_accept.sv
module crit_irq_accept #(
  parameter int PC_W    = 32,
  parameter int MSR_W   = 32,
  parameter int OFS_W   = 12,
  parameter int VEC_OFS = 'h020,
  parameter int CE_POS  = 17,
  parameter int GS_POS  = 28,
  parameter int SYN_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  crit_req_async,
  input  logic                  hi_pri_pend,
  input  logic [PC_W-1:0]       cur_pc,
  input  logic [PC_W-OFS_W-1:0] ivpr_pfx,
  input  logic                  msr_wr,
  input  logic [MSR_W-1:0]      msr_wdata,
  input  logic                  rfci,
  input  logic                  syn_upd,
  input  logic [1:0]            syn_mode,
  input  logic [SYN_W-1:0]      syn_bits,
  output logic                  take,
  output logic                  ret,
  output logic [PC_W-1:0]       redirect_pc,
  output logic [MSR_W-1:0]      msr,
  output logic [PC_W-1:0]       csrr0,
  output logic [MSR_W-1:0]      csrr1,
  output logic [SYN_W-1:0]      syn
);

  localparam logic [OFS_W-1:0] OFS = OFS_W'(VEC_OFS);
  localparam logic [MSR_W-1:0] EN_MASK = (MSR_W'(1) << CE_POS) | (MSR_W'(1) << GS_POS);

  logic req_s1, req_s2;
  logic enabled, accept;
  logic [SYN_W-1:0] syn_low;

  assign enabled = msr[CE_POS] | msr[GS_POS];
  assign accept  = req_s2 & enabled & ~hi_pri_pend & ~rfci;
  assign syn_low = syn_bits & (~syn_bits + SYN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
    end else begin
      req_s1 <= crit_req_async;
      req_s2 <= req_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take        <= 1'b0;
      ret         <= 1'b0;
      redirect_pc <= '0;
      msr         <= '0;
      csrr0       <= '0;
      csrr1       <= '0;
    end else begin
      take <= accept;
      ret  <= rfci;
      if (rfci) begin
        msr         <= csrr1;
        redirect_pc <= csrr0;
      end else if (accept) begin
        csrr0       <= cur_pc;
        csrr1       <= msr;
        msr         <= msr & ~EN_MASK;
        redirect_pc <= {ivpr_pfx, OFS};
      end else if (msr_wr) begin
        msr <= msr_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      syn <= '0;
    else if (syn_upd) begin
      case (syn_mode)
        2'd1:    syn <= syn_low;
        2'd2:    syn <= syn_bits;
        default: syn <= syn;
      endcase
    end
  end

endmodule

// File: rtl/crit_irq_accept_chk.sv
module crit_irq_accept_chk #(
  parameter int PC_W    = 32,
  parameter int MSR_W   = 32,
  parameter int OFS_W   = 12,
  parameter int VEC_OFS = 'h020,
  parameter int CE_POS  = 17,
  parameter int GS_POS  = 28,
  parameter int SYN_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hi_pri_pend,
  input logic             rfci,
  input logic             syn_upd,
  input logic [1:0]       syn_mode,
  input logic             take,
  input logic             ret,
  input logic [PC_W-1:0]  redirect_pc,
  input logic [MSR_W-1:0] msr,
  input logic [SYN_W-1:0] syn
);

  // R1
  take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) take |=> !take);

  // R3
  take_unblocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take) |-> !$past(hi_pri_pend));

  // R5
  vec_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> redirect_pc[OFS_W-1:0] == OFS_W'(VEC_OFS));

  // R6
  en_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (!msr[CE_POS] && !msr[GS_POS]));

  // R7
  ret_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfci |=> (ret && !take));

  // R8
  syn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!syn_upd || syn_mode == 2'd0) |=> $stable(syn));

  // R9
  syn_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_upd && syn_mode == 2'd1) |=> $onehot0(syn));

endmodule

bind crit_irq_accept crit_irq_accept_chk #(
  .PC_W(PC_W), .MSR_W(MSR_W), .OFS_W(OFS_W), .VEC_OFS(VEC_OFS),
  .CE_POS(CE_POS), .GS_POS(GS_POS), .SYN_W(SYN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hi_pri_pend(hi_pri_pend), .rfci(rfci),
  .syn_upd(syn_upd), .syn_mode(syn_mode), .take(take), .ret(ret),
  .redirect_pc(redirect_pc), .msr(msr), .syn(syn)
);

// File: tb/tb_crit_irq_accept.sv
`timescale 1ns/1ps
module tb_crit_irq_accept;
  localparam int PC_W = 32, MSR_W = 32, OFS_W = 12, SYN_W = 16;
  localparam int CE_POS = 17, GS_POS = 28;

  logic clk = 0, rst_n = 0;
  logic crit_req_async = 0, hi_pri_pend = 0, msr_wr = 0, rfci = 0, syn_upd = 0;
  logic [PC_W-1:0] cur_pc = '0;
  logic [PC_W-OFS_W-1:0] ivpr_pfx = '0;
  logic [MSR_W-1:0] msr_wdata = '0;
  logic [1:0] syn_mode = '0;
  logic [SYN_W-1:0] syn_bits = '0;
  logic take, ret;
  logic [PC_W-1:0] redirect_pc, csrr0;
  logic [MSR_W-1:0] msr, csrr1;
  logic [SYN_W-1:0] syn;

  int total = 0, bad = 0;
  bit done = 0;

  crit_irq_accept dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_msr(input logic [MSR_W-1:0] v);
    msr_wr = 1; msr_wdata = v;
    @(negedge clk);
    msr_wr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // ce, gs, hi, expected take
  localparam logic [3:0] VT [6] = '{4'b1001, 4'b0101, 4'b1101, 4'b0000, 4'b1010, 4'b0110};
  localparam logic [MSR_W-1:0] BASE = 32'h0000_1234;

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    if (!done) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int takes;
    logic [MSR_W-1:0] mv;
    logic [SYN_W-1:0] sv;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 take", take, 0);
    chk("R11 ret", ret, 0);
    chk("R11 msr", msr, 0);
    chk("R11 csrr0", csrr0, 0);
    chk("R11 csrr1", csrr1, 0);
    chk("R11 redirect", redirect_pc, 0);
    chk("R11 syn", syn, 0);

    // R2 R3 R5 R6 vector walk
    for (int k = 0; k < 6; k++) begin
      mv = BASE ^ MSR_W'(k << 4) | (MSR_W'(VT[k][3]) << CE_POS) | (MSR_W'(VT[k][2]) << GS_POS);
      wr_msr(mv);
      hi_pri_pend = VT[k][1];
      cur_pc = 32'h4000_0100 + 32'(k * 8);
      ivpr_pfx = 20'hABC00 + 20'(k);
      crit_req_async = 1;
      takes = 0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (take) takes++;
      end
      chk(VT[k][1] ? "R3 blocked take count" : "R2 enable take count", 64'(takes), 64'(VT[k][0]));
      if (VT[k][0]) begin
        chk("R5 vector", redirect_pc, {ivpr_pfx, 12'h020});
        chk("R6 csrr0", csrr0, cur_pc);
        chk("R6 csrr1", csrr1, mv);
        chk("R6 msr cleared", msr, mv & ~((32'd1 << CE_POS) | (32'd1 << GS_POS)));
      end else begin
        chk("R2 msr untouched", msr, mv);
      end
      crit_req_async = 0;
      idle(3);
      hi_pri_pend = 0;
      idle(1);
    end

    // R1 latency and width
    wr_msr(32'd1 << CE_POS);
    crit_req_async = 1;
    @(negedge clk); chk("R1 edge1", take, 0);
    @(negedge clk); chk("R1 edge2", take, 0);
    @(negedge clk); chk("R1 edge3", take, 1);
    @(negedge clk); chk("R1 pulse width", take, 0);
    crit_req_async = 0;
    idle(3);

    // R4 pending then enabled
    wr_msr(32'h0000_00F0);
    crit_req_async = 1;
    takes = 0;
    for (int c = 0; c < 5; c++) begin @(negedge clk); if (take) takes++; end
    chk("R4 masked no take", 64'(takes), 0);
    cur_pc = 32'h0000_8888;
    wr_msr(32'h0000_00F0 | (32'd1 << GS_POS));
    for (int c = 0; c < 5; c++) begin if (take) takes++; @(negedge clk); end
    chk("R4 taken once", 64'(takes), 1);
    chk("R4 saved msr", csrr1, 32'h0000_00F0 | (32'd1 << GS_POS));
    crit_req_async = 0;
    idle(3);

    // R7 return
    rfci = 1;
    @(negedge clk);
    rfci = 0;
    chk("R7 ret pulse", ret, 1);
    chk("R7 msr restore", msr, 32'h0000_00F0 | (32'd1 << GS_POS));
    chk("R7 redirect", redirect_pc, 32'h0000_8888);
    @(negedge clk);
    chk("R7 ret width", ret, 0);

    // R10 R9 R8 syndrome
    syn_upd = 1; syn_mode = 2; syn_bits = 16'hA5A5;
    @(negedge clk);
    chk("R10 subset load", syn, 16'hA5A5);
    syn_bits = 16'hFFFF;
    @(negedge clk);
    chk("R10 all bits", syn, 16'hFFFF);
    syn_mode = 1; syn_bits = 16'h0060;
    @(negedge clk);
    chk("R9 exclusive lowest", syn, 16'h0020);
    syn_bits = 16'h0000;
    @(negedge clk);
    chk("R9 exclusive none", syn, 16'h0000);
    syn_mode = 2; syn_bits = 16'h3C01;
    @(negedge clk);
    syn_mode = 0; syn_bits = 16'hFFFF;
    @(negedge clk);
    chk("R8 mode0 keeps", syn, 16'h3C01);
    syn_upd = 0; syn_mode = 1;
    @(negedge clk);
    chk("R8 no strobe keeps", syn, 16'h3C01);
    sv = syn;
    wr_msr(32'd1 << CE_POS);
    crit_req_async = 1;
    takes = 0;
    for (int c = 0; c < 5; c++) begin @(negedge clk); if (take) takes++; end
    chk("R8 take happened", 64'(takes), 1);
    chk("R8 take keeps syn", syn, sv);
    crit_req_async = 0;
    idle(3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule